// File: doc/BRIEF.md
# Pipelined-Address Local Bus Cycle Sequencer

This block is the bus master of a 16-bit local bus whose slaves can ask for the next address early. An internal client offers one transfer at a time: a word address, two byte lanes, memory/IO, data/code and read/write qualifiers, and write data. The sequencer accepts the transfer, puts out a one-clock address strobe with the address and qualifiers, and then waits in the data phase until the slave returns READY. On writes it drives the data bus for the whole data phase. On reads it captures the data bus on the clock where READY is sampled, and reports the completion to the client one clock later.

A slave can assert the next-address input (NA) during a data phase before READY. If a new transfer is waiting when NA is sampled, the sequencer issues the address and strobe of that transfer while the current cycle is still in wait states (state T2P). When the current cycle then completes, the already-addressed cycle goes directly into its data phase (T1P). If NA arrives when nothing is waiting, the sequencer parks in T2I. From T2I it can still pipeline a request that arrives later, as long as that request arrives before READY. Without NA, each cycle uses the plain T1 then T2 sequence. All control signals at the ports are active high. Any inversion to the pin levels is done outside the block.

Top module: `pipe_bus_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, the state output reads idle (code 0). The strobe, the data-bus enable, the response pulse and, with no request offered, the accept output are all low.
- R2: From idle, an offered request is accepted on the next edge. The sequencer then spends one clock in T1 (code 1) with the strobe high and the request's address on the bus, followed by T2 (code 2).
- R3: During a cycle's data phase, the bus address equals that cycle's address in every state except T2P. In T2P it equals the next cycle's address.
- R4: In T2 or T1P (code 3), READY low with NA high and a request offered causes three things on that edge: the request is accepted, the next state is T2P (code 4), and the strobe is high for that first T2P clock with the new address. The new address therefore appears before READY of the current cycle.
- R5: In T2 or T1P, READY low with NA high and no request offered leads to T2I (code 5). In T2I, a request offered while READY is low is accepted and leads to T2P.
- R6: In T2, T1P or T2I, READY high completes the cycle. The next state is T1 if a request is offered, which is then accepted, and idle otherwise.
- R7: In T2P, READY high leads to T1P with no new strobe. The pipelined cycle's data phase starts there, and NA in T1P continues pipelining into further cycles.
- R8: The strobe is high for exactly one clock per bus cycle. NA held high, or asserted again, while in T2P or T2I changes nothing.
- R9: NA sampled on the same edge as READY has no effect. The next cycle then starts with a plain T1.
- R10: The data-bus enable is high, with the write data on the bus, in every data-phase state of a write cycle. It is low in idle, in T1, and during read data phases.
- R11: One clock after each completion edge, the response pulse is high for one clock. The write flag gives the cycle kind, and for reads the returned data equals the data bus sampled on the completion edge.
- R12: The accept output is high only on clocks whose edge takes the offered request: from idle, at a completion, or on entry to T2P. It is never high in T1 or T2P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus state clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A transfer is offered |
| req_accept | output | 1 | The offered transfer is taken on this edge |
| req_addr | input | 23 | Word address of the offered transfer |
| req_be | input | 2 | Byte lanes (bit 1 high byte, bit 0 low byte) |
| req_mem | input | 1 | 1 = memory, 0 = IO |
| req_data | input | 1 | 1 = data, 0 = code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_write | output | 1 | Completed cycle was a write |
| rsp_rdata | output | 16 | Read data of the completed cycle |
| bus_ads | output | 1 | Address strobe |
| bus_addr | output | 23 | Bus word address |
| bus_be | output | 2 | Bus byte lanes |
| bus_mem | output | 1 | Memory/IO qualifier |
| bus_data | output | 1 | Data/code qualifier |
| bus_write | output | 1 | Write/read qualifier |
| bus_dout | output | 16 | Data bus out |
| bus_doe | output | 1 | Data bus output enable |
| bus_din | input | 16 | Data bus in |
| bus_ready | input | 1 | Slave ends the current cycle |
| bus_na | input | 1 | Slave requests the next address |
| bus_state | output | 3 | Current bus state code |

## Verification
The delicate cases are clocks where a cycle's completion coincides with the next cycle's setup. The first is READY sampled together with NA. The second is READY sampled in T2I on the same clock that a fresh request arrives. The third is READY in T2P, where the strobe of the next cycle has already gone out. The bench sweeps the wait-state count against the clock on which NA is raised, with NA either pulsed or held, and against three arrival patterns for the second request. From these it derives the expected state, strobe, address, accept, data-enable and response of every clock arithmetically, and compares them clock by clock. A directed chain of three alternating read and write cycles with NA held high shows pipelining carried from T1P into the next cycle.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int unsigned PBS_AW = 23;
    localparam int unsigned PBS_DW = 16;
    localparam int unsigned PBS_BW = PBS_DW / 8;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T1P  = 3'd3,
        ST_T2P  = 3'd4,
        ST_T2I  = 3'd5
    } bus_st_e;

    typedef struct packed {
        logic [PBS_AW-1:0] addr;
        logic [PBS_BW-1:0] be;
        logic              mem;
        logic              dat;
        logic              wr;
        logic [PBS_DW-1:0] wdata;
    } xfer_t;

    function automatic logic in_data_phase(bus_st_e s);
        return (s == ST_T2) || (s == ST_T1P) || (s == ST_T2P) || (s == ST_T2I);
    endfunction

endpackage

// File: rtl/pbs_fsm.sv
module pbs_fsm
    import pbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    req_valid,
    input  logic    bus_ready,
    input  logic    bus_na,
    output bus_st_e state,
    output logic    take,
    output logic    load_cur,
    output logic    load_nxt,
    output logic    promote,
    output logic    ads
);

    bus_st_e nxt_st;
    logic    fresh_q;
    logic    early;

    always_comb begin
        nxt_st   = state;
        take     = 1'b0;
        load_cur = 1'b0;
        load_nxt = 1'b0;
        promote  = 1'b0;
        early    = (state == ST_T2I) || bus_na;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    nxt_st   = ST_T1;
                    take     = 1'b1;
                    load_cur = 1'b1;
                end
            end
            ST_T1: nxt_st = ST_T2;
            ST_T2, ST_T1P, ST_T2I: begin
                if (bus_ready) begin
                    if (req_valid) begin
                        nxt_st   = ST_T1;
                        take     = 1'b1;
                        load_cur = 1'b1;
                    end else begin
                        nxt_st = ST_IDLE;
                    end
                end else if (early && req_valid) begin
                    nxt_st   = ST_T2P;
                    take     = 1'b1;
                    load_nxt = 1'b1;
                end else if (early) begin
                    nxt_st = ST_T2I;
                end else begin
                    nxt_st = ST_T2;
                end
            end
            ST_T2P: begin
                if (bus_ready) begin
                    nxt_st  = ST_T1P;
                    promote = 1'b1;
                end
            end
            default: nxt_st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            fresh_q <= 1'b0;
        end else begin
            state   <= nxt_st;
            fresh_q <= load_nxt;
        end
    end

    assign ads = (state == ST_T1) || ((state == ST_T2P) && fresh_q);

    assert_t1_then_t2_R2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T1) |=> (state == ST_T2));

    assert_pipe_entry_R4: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_T2 || state == ST_T1P) && !bus_ready && bus_na && req_valid)
        |=> (state == ST_T2P && ads));

    assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        (ads && state == ST_T2P) |=> !ads);

    assert_t2p_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T2P && bus_ready) |=> (state == ST_T1P && !ads));

    assert_idle_return_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T2I && bus_ready && !req_valid) |=> (state == ST_IDLE));

    assert_no_take_busy_R12: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T1 || state == ST_T2P) |-> !take);

endmodule

// File: rtl/pbs_slots.sv
module pbs_slots
    import pbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  xfer_t             req_in,
    input  logic              load_cur,
    input  logic              load_nxt,
    input  logic              promote,
    input  bus_st_e           state,
    output xfer_t             view,
    output logic [PBS_DW-1:0] dout,
    output logic              doe,
    output logic              cur_wr
);

    xfer_t cur_q;
    xfer_t nxt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
            nxt_q <= '0;
        end else begin
            if (load_cur)     cur_q <= req_in;
            else if (promote) cur_q <= nxt_q;
            if (load_nxt)     nxt_q <= req_in;
        end
    end

    assign view   = (state == ST_T2P) ? nxt_q : cur_q;
    assign dout   = cur_q.wdata;
    assign cur_wr = cur_q.wr;
    assign doe    = cur_q.wr && in_data_phase(state);

    assert_promote_carries_R7: assert property (@(posedge clk) disable iff (rst)
        promote |=> (cur_q == $past(nxt_q)));

    assert_no_drive_t1_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T1 || state == ST_IDLE) |-> !doe);

endmodule

// File: rtl/pbs_rdcap.sv
module pbs_rdcap
    import pbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done,
    input  logic              cur_wr,
    input  logic [PBS_DW-1:0] bus_din,
    output logic              rsp_valid,
    output logic              rsp_write,
    output logic [PBS_DW-1:0] rsp_rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_write <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= done;
            if (done) begin
                rsp_write <= cur_wr;
                if (!cur_wr) rsp_rdata <= bus_din;
            end
        end
    end

    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (rst)
        (done && !cur_wr) |=> (rsp_valid && !rsp_write && rsp_rdata == $past(bus_din)));

endmodule

// File: rtl/pipe_bus_seq.sv
module pipe_bus_seq
    import pbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_accept,
    input  logic [PBS_AW-1:0] req_addr,
    input  logic [PBS_BW-1:0] req_be,
    input  logic              req_mem,
    input  logic              req_data,
    input  logic              req_write,
    input  logic [PBS_DW-1:0] req_wdata,
    output logic              rsp_valid,
    output logic              rsp_write,
    output logic [PBS_DW-1:0] rsp_rdata,
    output logic              bus_ads,
    output logic [PBS_AW-1:0] bus_addr,
    output logic [PBS_BW-1:0] bus_be,
    output logic              bus_mem,
    output logic              bus_data,
    output logic              bus_write,
    output logic [PBS_DW-1:0] bus_dout,
    output logic              bus_doe,
    input  logic [PBS_DW-1:0] bus_din,
    input  logic              bus_ready,
    input  logic              bus_na,
    output logic [2:0]        bus_state
);

    bus_st_e st;
    xfer_t   req_in;
    xfer_t   view;
    logic    load_cur;
    logic    load_nxt;
    logic    promote;
    logic    cur_wr;
    logic    done;

    assign req_in = '{addr: req_addr, be: req_be, mem: req_mem,
                      dat: req_data, wr: req_write, wdata: req_wdata};

    pbs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .bus_ready (bus_ready),
        .bus_na    (bus_na),
        .state     (st),
        .take      (req_accept),
        .load_cur  (load_cur),
        .load_nxt  (load_nxt),
        .promote   (promote),
        .ads       (bus_ads)
    );

    pbs_slots u_slots (
        .clk      (clk),
        .rst      (rst),
        .req_in   (req_in),
        .load_cur (load_cur),
        .load_nxt (load_nxt),
        .promote  (promote),
        .state    (st),
        .view     (view),
        .dout     (bus_dout),
        .doe      (bus_doe),
        .cur_wr   (cur_wr)
    );

    assign done = in_data_phase(st) && bus_ready;

    pbs_rdcap u_rdcap (
        .clk       (clk),
        .rst       (rst),
        .done      (done),
        .cur_wr    (cur_wr),
        .bus_din   (bus_din),
        .rsp_valid (rsp_valid),
        .rsp_write (rsp_write),
        .rsp_rdata (rsp_rdata)
    );

    assign bus_addr  = view.addr;
    assign bus_be    = view.be;
    assign bus_mem   = view.mem;
    assign bus_data  = view.dat;
    assign bus_write = view.wr;
    assign bus_state = st;

endmodule

// File: tb/tb_pipe_bus_seq.sv
module tb_pipe_bus_seq;

    localparam logic [2:0] TI = 3'd0, T1 = 3'd1, T2 = 3'd2, T1P = 3'd3, T2P = 3'd4, T2I = 3'd5;
    localparam int L = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_mem = 1'b1, req_data = 1'b1, req_write = 1'b0;
    logic [22:0] req_addr = '0;
    logic [1:0]  req_be = 2'b11;
    logic [15:0] req_wdata = '0, bus_din = '0;
    logic bus_ready = 1'b0, bus_na = 1'b0;
    logic req_accept, rsp_valid, rsp_write, bus_ads, bus_mem, bus_data, bus_write, bus_doe;
    logic [15:0] rsp_rdata, bus_dout;
    logic [22:0] bus_addr;
    logic [1:0]  bus_be;
    logic [2:0]  bus_state;

    always #5 clk = ~clk;

    pipe_bus_seq dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_accept(req_accept),
        .req_addr(req_addr), .req_be(req_be), .req_mem(req_mem), .req_data(req_data),
        .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_write(rsp_write), .rsp_rdata(rsp_rdata), .bus_ads(bus_ads),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_mem(bus_mem), .bus_data(bus_data),
        .bus_write(bus_write), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
        .bus_ready(bus_ready), .bus_na(bus_na), .bus_state(bus_state)
    );

    int n_run = 0;
    int n_fail = 0;

    logic [2:0]  exp_st [L];
    bit          exp_ads [L], exp_am [L], exp_acc [L], exp_doe [L], exp_rsp [L], exp_rw [L];
    logic [22:0] exp_addr [L];
    logic [15:0] exp_dout [L], exp_rd [L];
    bit          rdy_at [L], na_at [L];
    logic [22:0] q_addr [3];
    bit          q_wr [3];
    logic [15:0] q_wd [3];
    int          q_av [3];
    int          nq, clen;

    function automatic logic [15:0] din_of(int k);
        return 16'h3C00 | 16'(k * 37);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic clear_exp();
        for (int k = 0; k < L; k++) begin
            exp_st[k] = TI; exp_ads[k] = 0; exp_am[k] = 0; exp_acc[k] = 0;
            exp_doe[k] = 0; exp_rsp[k] = 0; exp_rw[k] = 0; exp_addr[k] = '0;
            exp_dout[k] = '0; exp_rd[k] = '0; rdy_at[k] = 0; na_at[k] = 0;
        end
    endtask

    // one data-phase clock of request qi at clock c, address shown from request ai
    task automatic set_data(int c, logic [2:0] s, int qi, int ai);
        exp_st[c] = s; exp_am[c] = 1; exp_addr[c] = q_addr[ai];
        exp_doe[c] = q_wr[qi]; exp_dout[c] = q_wd[qi];
    endtask

    task automatic set_done(int c, int qi);
        rdy_at[c] = 1;
        exp_rsp[c+1] = 1; exp_rw[c+1] = q_wr[qi];
        exp_rd[c+1] = din_of(c);
    endtask

    task automatic run_case(input string tag, input int sc);
        int qi = 0;
        for (int k = 0; k < clen; k++) begin
            bus_ready = rdy_at[k];
            bus_na    = na_at[k];
            bus_din   = din_of(k);
            req_valid = (qi < nq) && (k >= q_av[qi]);
            req_addr  = (qi < nq) ? q_addr[qi] : '0;
            req_write = (qi < nq) ? q_wr[qi] : 1'b0;
            req_wdata = (qi < nq) ? q_wd[qi] : '0;
            #1;
            chk(bus_state === exp_st[k], tag, $sformatf("state case %0d clk %0d", sc, k),
                32'(bus_state), 32'(exp_st[k]));
            chk(bus_ads === exp_ads[k], tag, $sformatf("strobe case %0d clk %0d", sc, k),
                32'(bus_ads), 32'(exp_ads[k]));
            if (exp_am[k])
                chk(bus_addr === exp_addr[k], "R3", $sformatf("address case %0d clk %0d", sc, k),
                    32'(bus_addr), 32'(exp_addr[k]));
            chk(req_accept === exp_acc[k], "R12", $sformatf("accept case %0d clk %0d", sc, k),
                32'(req_accept), 32'(exp_acc[k]));
            chk(bus_doe === exp_doe[k] && (!exp_doe[k] || bus_dout === exp_dout[k]), "R10",
                $sformatf("drive case %0d clk %0d", sc, k),
                {15'd0, bus_doe, bus_dout}, {15'd0, exp_doe[k], exp_dout[k]});
            chk(rsp_valid === exp_rsp[k] &&
                (!exp_rsp[k] || (rsp_write === exp_rw[k] && (exp_rw[k] || rsp_rdata === exp_rd[k]))),
                "R11", $sformatf("response case %0d clk %0d", sc, k),
                {14'd0, rsp_valid, rsp_write, rsp_rdata}, {14'd0, exp_rsp[k], exp_rw[k], exp_rd[k]});
            if (req_accept === 1'b1) qi++;
            @(posedge clk); #1;
        end
        req_valid = 0; bus_ready = 0; bus_na = 0;
    endtask

    // sweep: w wait states for cycle A, NA first sampled in A's data clock np,
    // pend 0 = no second request, 1 = second waiting from the start, 2 = second arrives in T2I
    task automatic sweep_case(int w, int np, int pend, bit hold, int sc);
        int  ra = 2 + w;
        bit  pipe;
        int  bads;
        string tag;
        clear_exp();
        nq = (pend == 0) ? 1 : 2;
        q_addr[0] = 23'h400000 ^ 23'(sc * 291); q_wr[0] = sc[0]; q_wd[0] = 16'h1000 + 16'(sc);
        q_addr[1] = 23'h0A5000 ^ 23'(sc * 77);  q_wr[1] = !sc[0]; q_wd[1] = 16'h2000 + 16'(sc);
        q_av[0] = 0;
        q_av[1] = (pend == 1) ? 1 : 3 + np;
        pipe = (np < w) && (pend == 1 || (pend == 2 && w - np >= 2));
        tag = hold ? "R8" : pipe ? "R4" : (np < w) ? "R5/R6" : (np == w && pend == 1) ? "R9" : "R2";
        exp_acc[0] = 1;
        exp_st[1] = T1; exp_ads[1] = 1; exp_am[1] = 1; exp_addr[1] = q_addr[0];
        if (np <= w) begin
            na_at[2+np] = 1;
            if (hold) for (int c = 2 + np; c <= ra; c++) na_at[c] = 1;
        end
        for (int d = 0; d <= w; d++) begin
            logic [2:0] s = T2;
            if (np < w && d > np) begin
                if (pend == 1) s = T2P;
                else if (pend == 2 && d > np + 1) s = T2P;
                else s = T2I;
            end
            set_data(2 + d, s, 0, (s == T2P) ? 1 : 0);
        end
        set_done(ra, 0);
        if (pipe) begin
            bads = (pend == 1) ? 3 + np : 4 + np;
            exp_ads[bads] = 1; exp_acc[bads-1] = 1;
            set_data(ra + 1, T1P, 1, 1);
            set_done(ra + 1, 1);
        end else if (nq == 2 && q_av[1] <= ra) begin
            exp_acc[ra] = 1;
            exp_st[ra+1] = T1; exp_ads[ra+1] = 1; exp_am[ra+1] = 1; exp_addr[ra+1] = q_addr[1];
            set_data(ra + 2, T2, 1, 1);
            set_done(ra + 2, 1);
        end
        clen = ra + 4;
        run_case(tag, sc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int sc = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values while reset is held
        chk(bus_state === TI && bus_ads === 1'b0 && bus_doe === 1'b0 && rsp_valid === 1'b0
            && req_accept === 1'b0, "R1", "reset outputs",
            {27'd0, bus_state, bus_ads, bus_doe}, 32'd0);
        rst = 1'b0;
        @(posedge clk); #1;
        chk(bus_state === TI && bus_ads === 1'b0 && rsp_valid === 1'b0 && req_accept === 1'b0,
            "R1", "first clock after reset", {28'd0, bus_state, bus_ads}, 32'd0);

        for (int w = 0; w <= 3; w++)
            for (int np = 0; np <= w + 1; np++)
                for (int pend = 0; pend <= 2; pend++)
                    for (int hold = 0; hold <= 1; hold++) begin
                        if (pend == 2 && np >= w) continue;
                        if (hold == 1 && np > w) continue;
                        sweep_case(w, np, pend, bit'(hold), sc);
                        sc++;
                    end

        // R7: three back-to-back cycles, write/read/write, NA held high throughout
        clear_exp();
        nq = 3;
        q_addr[0] = 23'h012345; q_wr[0] = 1; q_wd[0] = 16'hA1A1; q_av[0] = 0;
        q_addr[1] = 23'h054321; q_wr[1] = 0; q_wd[1] = 16'hB2B2; q_av[1] = 0;
        q_addr[2] = 23'h7F00FF; q_wr[2] = 1; q_wd[2] = 16'hC3C3; q_av[2] = 0;
        for (int c = 0; c < 9; c++) na_at[c] = 1;
        exp_acc[0] = 1;
        exp_st[1] = T1; exp_ads[1] = 1; exp_am[1] = 1; exp_addr[1] = q_addr[0];
        set_data(2, T2, 0, 0);  exp_acc[2] = 1;
        set_data(3, T2P, 0, 1); exp_ads[3] = 1; set_done(3, 0);
        set_data(4, T1P, 1, 1); exp_acc[4] = 1;
        set_data(5, T2P, 1, 2); exp_ads[5] = 1; set_done(5, 1);
        set_data(6, T1P, 2, 2);
        set_data(7, T2I, 2, 2); set_done(7, 2);
        clen = 10;
        run_case("R7", sc);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule